// File: doc/BRIEF.md
# Hybrid Directory Coherence Controller

This block is the directory logic that sits beside one memory bank in a write-through cache system. The level-one caches send it read and write requests. The bank always holds current data, so the directory does not track ownership. It tracks only which caches hold a copy of each line. On a read, the requesting cache is added to that line's short sharer list. If the list is already full, the line is marked as overflowed instead.

On a write, the directory chooses the coherence action line by line. If the line has not overflowed, a single update message is sent on the coherence port. That message carries the new data and a bit mask of the listed sharers. If the line has overflowed, one invalidate goes to every cache. In both cases the writer is left out of the targets.

The write is acknowledged to its requester on the response port only after every expected coherence acknowledgement has come back. When a broadcast completes, the line's entry is emptied and the line returns to update mode. While a line has coherence acknowledgements outstanding, new requests to that line are held off. Requests to other lines keep flowing, as long as a transaction slot is free for a write that needs one.

Top module: `hdc_dir_ctrl`

## Requirements
- R1: After reset `rsp_valid` and `coh_valid` are low and every directory entry is empty, so a first write to any line is answered on the response port one cycle after it is accepted, with no coherence message.
- R2: An accepted read returns a response (`rsp_write`=0, same cache and line) in the cycle after acceptance. It adds the reader to the line's list when the reader is not already listed. A reader that is already listed is not added a second time.
- R3: A line holds up to LIST_DEPTH (4) distinct sharers in update mode. A read by a further distinct cache sets the line's overflow flag and does not grow the list.
- R4: A write to a line that has not overflowed and has at least one sharer other than the writer produces, one cycle after acceptance, a coherence message with `coh_inval`=0, `coh_data` equal to the write data and `coh_line` equal to the line.
- R5: The coherence target mask has bit k set exactly for each target cache k. The writing cache is never a target.
- R6: A write with no target caches (no sharer other than the writer, line not overflowed) is answered one cycle after acceptance and sends no coherence message.
- R7: A write that sends coherence traffic is answered only in the cycle after its last expected acknowledgement. The expected count is the number of set bits in the target mask. An acknowledgement counts only when `ack_line` matches a line that has a write in progress. Other acknowledgements have no effect.
- R8: A write to an overflowed line sends one message with `coh_inval`=1 and a mask of all N_CACHES caches except the writer, so N_CACHES-1 acknowledgements are expected.
- R9: Once a broadcast invalidate completes, the line's list is empty and its overflow flag is clear. The next write to it is answered at once (as in R6), and later reads bring it back to update mode.
- R10: While a line has a write in progress, `req_ready` is low for any request to that line. A request to another line is accepted in the same cycle.
- R11: In a cycle where an acknowledgement completes a write, `req_ready` is low. The request is accepted in the next cycle.
- R12: When all N_TXN (2) transaction slots hold writes in progress, `req_ready` is low for a write that needs coherence traffic. Reads stay accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cache | input | CID_W (3) | Requesting cache ID |
| req_line | input | LINE_W (4) | Line index |
| req_data | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response pulse on the direct port |
| rsp_write | output | 1 | Response is for a write |
| rsp_cache | output | CID_W (3) | Cache the response is for |
| rsp_line | output | LINE_W (4) | Line of the response |
| coh_valid | output | 1 | Coherence message pulse |
| coh_inval | output | 1 | 1 = invalidate broadcast, 0 = update multicast |
| coh_mask | output | N_CACHES (8) | One bit per target cache |
| coh_line | output | LINE_W (4) | Line of the coherence message |
| coh_data | output | DATA_W (32) | New data carried by an update |
| ack_valid | input | 1 | One coherence acknowledgement |
| ack_line | input | LINE_W (4) | Line the acknowledgement belongs to |

## Verification
Some properties are checked by assertions on every cycle. They check that the writer never appears in a coherence mask, that a broadcast always covers all other caches, and that a sharer list never grows past its depth. They also check that overflow is set only on a full list, that no two live transactions share a line, that a live transaction always has acknowledgements outstanding, and that the directory is never written and cleared in the same cycle. Other behaviours can only be shown by the bench's scenarios, because they depend on history across many requests. These are the exact target set after a series of reads, the switch to broadcast at the fifth distinct reader, the emptied entry after an invalidate, the response held back until the last matching acknowledgement, and the stalls on a busy line, at completion and with full slots.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  typedef enum logic {
    MODE_UPDATE = 1'b0,
    MODE_INVAL  = 1'b1
  } coh_mode_e;

  // number of set bits in a vector of up to 64 bits
  function automatic int unsigned f_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/hdc_dir_store.sv
module hdc_dir_store #(
  parameter int N_LINES    = 16,
  parameter int N_CACHES   = 8,
  parameter int LIST_DEPTH = 4,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int CID_W  = $clog2(N_CACHES),
  localparam int CNT_W  = $clog2(LIST_DEPTH + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LINE_W-1:0]                     rd_line,
  output logic [LIST_DEPTH-1:0][CID_W-1:0]      rd_ids,
  output logic [CNT_W-1:0]                      rd_cnt,
  output logic                                  rd_ovf,
  input  logic                                  wr_en,
  input  logic [LINE_W-1:0]                     wr_line,
  input  logic [LIST_DEPTH-1:0][CID_W-1:0]      wr_ids,
  input  logic [CNT_W-1:0]                      wr_cnt,
  input  logic                                  wr_ovf,
  input  logic                                  clr_en,
  input  logic [LINE_W-1:0]                     clr_line
);

  logic [LIST_DEPTH-1:0][CID_W-1:0] ids_q [N_LINES];
  logic [CNT_W-1:0]                 cnt_q [N_LINES];
  logic [N_LINES-1:0]               ovf_q;

  assign rd_ids = ids_q[rd_line];
  assign rd_cnt = cnt_q[rd_line];
  assign rd_ovf = ovf_q[rd_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < N_LINES; l++) begin
        ids_q[l] <= '0;
        cnt_q[l] <= '0;
      end
      ovf_q <= '0;
    end else if (wr_en) begin
      ids_q[wr_line] <= wr_ids;
      cnt_q[wr_line] <= wr_cnt;
      ovf_q[wr_line] <= wr_ovf;
    end else if (clr_en) begin
      ids_q[clr_line] <= '0;
      cnt_q[clr_line] <= '0;
      ovf_q[clr_line] <= 1'b0;
    end
  end

  // R3: the list never holds more than its depth
  p_list_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt <= CNT_W'(LIST_DEPTH)));

  // R3: overflow is only recorded on a full list
  p_ovf_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ovf) |-> (wr_cnt == CNT_W'(LIST_DEPTH)));

  // R11: completion and a new request never touch the directory together
  p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));

endmodule

// File: rtl/hdc_share_calc.sv
module hdc_share_calc
  import hdc_pkg::*;
#(
  parameter int N_CACHES   = 8,
  parameter int LIST_DEPTH = 4,
  localparam int CID_W = $clog2(N_CACHES),
  localparam int CNT_W = $clog2(LIST_DEPTH + 1),
  localparam int ACK_W = $clog2(N_CACHES)
) (
  input  logic [LIST_DEPTH-1:0][CID_W-1:0] ids,
  input  logic [CNT_W-1:0]                 cnt,
  input  logic                             ovf,
  input  logic [CID_W-1:0]                 req_cache,
  output logic                             hit,
  output logic                             upd,
  output logic [LIST_DEPTH-1:0][CID_W-1:0] nxt_ids,
  output logic [CNT_W-1:0]                 nxt_cnt,
  output logic                             nxt_ovf,
  output logic [N_CACHES-1:0]              tgt_mask,
  output logic [ACK_W-1:0]                 tgt_cnt
);

  // caches named by the valid part of the list, as a bit mask
  function automatic logic [N_CACHES-1:0] f_held(
    input logic [LIST_DEPTH-1:0][CID_W-1:0] l_ids,
    input logic [CNT_W-1:0]                 l_cnt
  );
    logic [N_CACHES-1:0] m;
    m = '0;
    for (int i = 0; i < LIST_DEPTH; i++) begin
      if (CNT_W'(i) < l_cnt) m[l_ids[i]] = 1'b1;
    end
    return m;
  endfunction

  logic [N_CACHES-1:0] held;
  logic [N_CACHES-1:0] self_bit;

  always_comb begin
    held     = f_held(ids, cnt);
    self_bit = {{(N_CACHES-1){1'b0}}, 1'b1} << req_cache;
    hit      = held[req_cache];
    tgt_mask = (ovf ? {N_CACHES{1'b1}} : held) & ~self_bit;
    tgt_cnt  = ACK_W'(f_ones(64'(tgt_mask)));
    nxt_ids  = ids;
    nxt_cnt  = cnt;
    nxt_ovf  = ovf;
    upd      = 1'b0;
    if (!hit && !ovf) begin
      upd = 1'b1;
      if (cnt < CNT_W'(LIST_DEPTH)) begin
        for (int i = 0; i < LIST_DEPTH; i++) begin
          if (CNT_W'(i) == cnt) nxt_ids[i] = req_cache;
        end
        nxt_cnt = cnt + CNT_W'(1);
      end else begin
        nxt_ovf = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdc_txn_table.sv
module hdc_txn_table
  import hdc_pkg::*;
#(
  parameter int N_TXN    = 2,
  parameter int N_LINES  = 16,
  parameter int N_CACHES = 8,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int CID_W  = $clog2(N_CACHES),
  localparam int ACK_W  = $clog2(N_CACHES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] q_line,
  output logic              q_busy,
  output logic              full,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [CID_W-1:0]  alloc_cache,
  input  logic [ACK_W-1:0]  alloc_cnt,
  input  logic              alloc_inval,
  input  logic              ack_valid,
  input  logic [LINE_W-1:0] ack_line,
  output logic              done,
  output logic [LINE_W-1:0] done_line,
  output logic [CID_W-1:0]  done_cache,
  output logic              done_inval
);

  logic [N_TXN-1:0] vld_q;
  logic [LINE_W-1:0] line_q  [N_TXN];
  logic [CID_W-1:0]  cache_q [N_TXN];
  logic [ACK_W-1:0]  cnt_q   [N_TXN];
  coh_mode_e         mode_q  [N_TXN];

  logic [N_TXN-1:0] ack_hit;
  logic [N_TXN-1:0] free_sel;

  always_comb begin
    q_busy     = 1'b0;
    free_sel   = '0;
    ack_hit    = '0;
    done       = 1'b0;
    done_line  = '0;
    done_cache = '0;
    done_inval = 1'b0;
    for (int i = 0; i < N_TXN; i++) begin
      if (vld_q[i] && line_q[i] == q_line) q_busy = 1'b1;
      if (ack_valid && vld_q[i] && line_q[i] == ack_line) begin
        ack_hit[i] = 1'b1;
        done       = (cnt_q[i] == ACK_W'(1));
        done_line  = line_q[i];
        done_cache = cache_q[i];
        done_inval = (mode_q[i] == MODE_INVAL);
      end
    end
    for (int i = N_TXN - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_sel = N_TXN'(1) << i;
    end
  end

  assign full = &vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N_TXN; i++) begin
        line_q[i]  <= '0;
        cache_q[i] <= '0;
        cnt_q[i]   <= '0;
        mode_q[i]  <= MODE_UPDATE;
      end
    end else begin
      for (int i = 0; i < N_TXN; i++) begin
        if (alloc_en && free_sel[i]) begin
          vld_q[i]   <= 1'b1;
          line_q[i]  <= alloc_line;
          cache_q[i] <= alloc_cache;
          cnt_q[i]   <= alloc_cnt;
          mode_q[i]  <= alloc_inval ? MODE_INVAL : MODE_UPDATE;
        end else if (ack_hit[i]) begin
          if (cnt_q[i] == ACK_W'(1)) vld_q[i] <= 1'b0;
          cnt_q[i] <= cnt_q[i] - ACK_W'(1);
        end
      end
    end
  end

  // R12: a slot is only taken when one is free
  p_alloc_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  for (genvar g = 0; g < N_TXN; g++) begin : g_slot
    // R7: a live transaction always waits for at least one ack
    p_live_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g] |-> (cnt_q[g] != '0));
    for (genvar h = g + 1; h < N_TXN; h++) begin : g_pair
      // R10: one transaction per line at most
      p_unique_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q[g] && vld_q[h] && line_q[g] == line_q[h]));
    end
  end

endmodule

// File: rtl/hdc_dir_ctrl.sv
module hdc_dir_ctrl #(
  parameter int N_CACHES   = 8,
  parameter int N_LINES    = 16,
  parameter int LIST_DEPTH = 4,
  parameter int N_TXN      = 2,
  parameter int DATA_W     = 32,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int CID_W  = $clog2(N_CACHES),
  localparam int CNT_W  = $clog2(LIST_DEPTH + 1),
  localparam int ACK_W  = $clog2(N_CACHES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [CID_W-1:0]    req_cache,
  input  logic [LINE_W-1:0]   req_line,
  input  logic [DATA_W-1:0]   req_data,
  output logic                rsp_valid,
  output logic                rsp_write,
  output logic [CID_W-1:0]    rsp_cache,
  output logic [LINE_W-1:0]   rsp_line,
  output logic                coh_valid,
  output logic                coh_inval,
  output logic [N_CACHES-1:0] coh_mask,
  output logic [LINE_W-1:0]   coh_line,
  output logic [DATA_W-1:0]   coh_data,
  input  logic                ack_valid,
  input  logic [LINE_W-1:0]   ack_line
);

  logic [LIST_DEPTH-1:0][CID_W-1:0] cur_ids, nxt_ids;
  logic [CNT_W-1:0]                 cur_cnt, nxt_cnt;
  logic                             cur_ovf, nxt_ovf;
  logic                             hit, upd;
  logic [N_CACHES-1:0]              tgt_mask;
  logic [ACK_W-1:0]                 tgt_cnt;

  logic              line_busy, slots_full;
  logic              done, done_inval;
  logic [LINE_W-1:0] done_line;
  logic [CID_W-1:0]  done_cache;

  // named internal events
  logic fire;
  logic ev_read_add;
  logic ev_write_quiet;
  logic ev_write_coh;
  logic ev_complete;
  logic need_coh;

  assign need_coh       = (tgt_cnt != '0);
  assign req_ready      = !line_busy && !done && !(req_write && need_coh && slots_full);
  assign fire           = req_valid && req_ready;
  assign ev_read_add    = fire && !req_write && upd;
  assign ev_write_quiet = fire && req_write && !need_coh;
  assign ev_write_coh   = fire && req_write && need_coh;
  assign ev_complete    = done;

  hdc_dir_store #(
    .N_LINES(N_LINES), .N_CACHES(N_CACHES), .LIST_DEPTH(LIST_DEPTH)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .rd_line(req_line), .rd_ids(cur_ids), .rd_cnt(cur_cnt), .rd_ovf(cur_ovf),
    .wr_en(ev_read_add), .wr_line(req_line), .wr_ids(nxt_ids),
    .wr_cnt(nxt_cnt), .wr_ovf(nxt_ovf),
    .clr_en(ev_complete && done_inval), .clr_line(done_line)
  );

  hdc_share_calc #(
    .N_CACHES(N_CACHES), .LIST_DEPTH(LIST_DEPTH)
  ) i_calc (
    .ids(cur_ids), .cnt(cur_cnt), .ovf(cur_ovf), .req_cache(req_cache),
    .hit(hit), .upd(upd), .nxt_ids(nxt_ids), .nxt_cnt(nxt_cnt),
    .nxt_ovf(nxt_ovf), .tgt_mask(tgt_mask), .tgt_cnt(tgt_cnt)
  );

  hdc_txn_table #(
    .N_TXN(N_TXN), .N_LINES(N_LINES), .N_CACHES(N_CACHES)
  ) i_txn (
    .clk(clk), .rst_n(rst_n),
    .q_line(req_line), .q_busy(line_busy), .full(slots_full),
    .alloc_en(ev_write_coh), .alloc_line(req_line), .alloc_cache(req_cache),
    .alloc_cnt(tgt_cnt), .alloc_inval(cur_ovf),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .done(done), .done_line(done_line), .done_cache(done_cache),
    .done_inval(done_inval)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_cache <= '0;
      rsp_line  <= '0;
      coh_valid <= 1'b0;
      coh_inval <= 1'b0;
      coh_mask  <= '0;
      coh_line  <= '0;
      coh_data  <= '0;
    end else begin
      rsp_valid <= ev_complete || (fire && !ev_write_coh);
      if (ev_complete) begin
        rsp_write <= 1'b1;
        rsp_cache <= done_cache;
        rsp_line  <= done_line;
      end else if (fire) begin
        rsp_write <= req_write;
        rsp_cache <= req_cache;
        rsp_line  <= req_line;
      end
      coh_valid <= ev_write_coh;
      if (ev_write_coh) begin
        coh_inval <= cur_ovf;
        coh_mask  <= tgt_mask;
        coh_line  <= req_line;
        coh_data  <= req_data;
      end
    end
  end

  // R5: the writer never receives its own coherence message
  p_no_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coh_valid |-> !coh_mask[$past(req_cache)]);

  // R8: a broadcast reaches every cache but the writer
  p_inval_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_valid && coh_inval) |-> ($countones(coh_mask) == N_CACHES - 1));

  // R4: an update never goes out with an empty mask
  p_update_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coh_valid |-> (coh_mask != '0));

endmodule

// File: tb/test_hdc_dir_ctrl.sv
module test_hdc_dir_ctrl;

  localparam int NC = 8;
  localparam int NL = 16;
  localparam int LD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_cache = '0;
  logic [3:0]  req_line = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid, rsp_write;
  logic [2:0]  rsp_cache;
  logic [3:0]  rsp_line;
  logic        coh_valid, coh_inval;
  logic [7:0]  coh_mask;
  logic [3:0]  coh_line;
  logic [31:0] coh_data;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_line = '0;

  int checks = 0;
  int errors = 0;

  int m_ids [NL][LD];
  int m_cnt [NL];
  bit m_ovf [NL];

  always #10 clk = ~clk;

  hdc_dir_ctrl i_hdc_dir_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cache(req_cache), .req_line(req_line), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_cache(rsp_cache),
    .rsp_line(rsp_line),
    .coh_valid(coh_valid), .coh_inval(coh_inval), .coh_mask(coh_mask),
    .coh_line(coh_line), .coh_data(coh_data),
    .ack_valid(ack_valid), .ack_line(ack_line)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_targets(input int l, input int w);
    logic [7:0] m;
    m = '0;
    if (m_ovf[l]) m = 8'hFF;
    else for (int i = 0; i < m_cnt[l]; i++) m[m_ids[l][i]] = 1'b1;
    m[w] = 1'b0;
    return m;
  endfunction

  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic void model_read(input int l, input int c);
    bit found = 0;
    for (int i = 0; i < m_cnt[l]; i++) if (m_ids[l][i] == c) found = 1;
    if (!found && !m_ovf[l]) begin
      if (m_cnt[l] < LD) begin
        m_ids[l][m_cnt[l]] = c;
        m_cnt[l]++;
      end else m_ovf[l] = 1;
    end
  endfunction

  task automatic put_req(input bit w, input int c, input int l, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_cache = 3'(c); req_line = 4'(l); req_data = d;
    #5;
    while (!req_ready) begin
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ack(input int l);
    @(negedge clk);
    ack_valid = 1'b1; ack_line = 4'(l);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_read(input int c, input int l);
    put_req(1'b0, c, l, 32'h0);
    chk(rsp_valid && !rsp_write && rsp_cache == 3'(c) && rsp_line == 4'(l), "R2 read response",
        {rsp_valid, rsp_write, rsp_cache, rsp_line}, {1'b1, 1'b0, 3'(c), 4'(l)});
    model_read(l, c);
  endtask

  task automatic do_write(input int c, input int l, input logic [31:0] d);
    logic [7:0] m;
    int n;
    bit ov;
    m = exp_targets(l, c);
    n = ones8(m);
    ov = m_ovf[l];
    put_req(1'b1, c, l, d);
    if (n == 0) begin
      chk(rsp_valid && rsp_write && rsp_cache == 3'(c) && !coh_valid, "R6 quiet write",
          {rsp_valid, rsp_write, rsp_cache, coh_valid}, {1'b1, 1'b1, 3'(c), 1'b0});
    end else begin
      chk(coh_valid && coh_inval == ov && coh_line == 4'(l), ov ? "R8 invalidate kind" : "R4 update kind",
          {coh_valid, coh_inval, coh_line}, {1'b1, ov, 4'(l)});
      chk(coh_mask == m, ov ? "R8 broadcast mask" : "R5 target mask", coh_mask, m);
      if (!ov) chk(coh_data == d, "R4 update data", coh_data, d);
      chk(!rsp_valid, "R7 no early response", rsp_valid, 0);
      for (int k = 0; k < n; k++) begin
        send_ack(l);
        if (k < n - 1) chk(!rsp_valid, "R7 waiting for acks", rsp_valid, 0);
        else chk(rsp_valid && rsp_write && rsp_cache == 3'(c) && rsp_line == 4'(l), "R7 completion",
                 {rsp_valid, rsp_write, rsp_cache, rsp_line}, {1'b1, 1'b1, 3'(c), 4'(l)});
      end
      if (ov) begin
        m_cnt[l] = 0;
        m_ovf[l] = 0;
      end
    end
  endtask

  // starts a write that needs coherence traffic and leaves it pending
  task automatic start_write(input int c, input int l);
    put_req(1'b1, c, l, 32'hA5A5_0000 + 32'(l));
    chk(coh_valid && !rsp_valid, "R7 pending write", {coh_valid, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      m_cnt[l] = 0;
      m_ovf[l] = 0;
      for (int i = 0; i < LD; i++) m_ids[l][i] = 0;
    end
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !coh_valid, "R1 reset outputs", {rsp_valid, coh_valid}, 2'b00);
    put_req(1'b1, 0, 9, 32'h1);
    chk(rsp_valid && rsp_write && !coh_valid, "R1 empty directory", {rsp_valid, rsp_write, coh_valid}, 3'b110);

    // R2 / R4 / R5
    do_read(2, 1);
    do_read(2, 1);
    do_read(3, 1);
    do_write(5, 1, 32'hDEAD_BEEF);
    do_write(2, 1, 32'h1234_5678);
    do_write(2, 3, 32'h0);

    // R3 / R8 / R9: four readers stay in update mode, the fifth overflows
    for (int c = 0; c < 4; c++) do_read(c, 4);
    do_read(0, 4);
    do_write(5, 4, 32'h0000_0F0F);
    do_read(6, 4);
    do_write(5, 4, 32'h0000_BBBB);
    do_write(5, 4, 32'h0000_CCCC);
    do_read(1, 4);
    do_write(6, 4, 32'h0000_DDDD);

    // R10: stall on a busy line, other lines flow
    do_read(2, 7);
    start_write(3, 7);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cache = 3'd4; req_line = 4'd7;
    #5;
    chk(!req_ready, "R10 busy line stalls", req_ready, 0);
    req_line = 4'd8;
    #1;
    chk(req_ready, "R10 other line accepted", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_line == 4'd8, "R10 other line answered", {rsp_valid, rsp_line}, {1'b1, 4'd8});
    model_read(8, 4);
    send_ack(8);
    chk(!rsp_valid, "R7 unrelated ack ignored", rsp_valid, 0);

    // R11: completion blocks a new request for one cycle
    @(negedge clk);
    ack_valid = 1'b1; ack_line = 4'd7;
    req_valid = 1'b1; req_write = 1'b0; req_cache = 3'd1; req_line = 4'd9;
    #5;
    chk(!req_ready, "R11 stall at completion", req_ready, 0);
    @(negedge clk);
    ack_valid = 1'b0;
    chk(rsp_valid && rsp_write && rsp_line == 4'd7 && rsp_cache == 3'd3, "R7 completion line 7",
        {rsp_valid, rsp_write, rsp_line}, {1'b1, 1'b1, 4'd7});
    #5;
    chk(req_ready, "R11 accepted next cycle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_write && rsp_line == 4'd9, "R11 read answered", {rsp_valid, rsp_write, rsp_line}, {1'b1, 1'b0, 4'd9});
    model_read(9, 1);

    // R12: both slots busy
    do_read(2, 10);
    do_read(2, 11);
    do_read(2, 12);
    start_write(3, 10);
    start_write(3, 11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cache = 3'd3; req_line = 4'd12;
    #5;
    chk(!req_ready, "R12 write stalls when full", req_ready, 0);
    req_write = 1'b0; req_cache = 3'd5;
    #1;
    chk(req_ready, "R12 read still accepted", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_write && rsp_line == 4'd12, "R12 read answered", {rsp_valid, rsp_line}, {1'b1, 4'd12});
    model_read(12, 5);
    send_ack(10);
    chk(rsp_valid && rsp_line == 4'd10, "R7 slot 10 done", {rsp_valid, rsp_line}, {1'b1, 4'd10});
    send_ack(11);
    chk(rsp_valid && rsp_line == 4'd11, "R7 slot 11 done", {rsp_valid, rsp_line}, {1'b1, 4'd11});
    do_write(3, 12, 32'h0000_1212);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int l, c;
      l = int'($urandom % NL);
      c = int'($urandom % NC);
      if ($urandom % 3 == 0) do_write(c, l, $urandom);
      else do_read(c, l);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule